// File: doc/BRIEF.md
# Address PROM Signature Scanner

The scanner reads bytes one at a time from a station-address PROM port and looks for a fixed eight-byte marker pattern (FF 00 55 AA FF 00 55 AA). The PROM's internal read counter may begin anywhere, so the search is bounded. When the marker is found, the scanner reads the six-byte station address that follows it, then a two-byte checksum, and compares that checksum with one it computes over the address.

A run begins with a `start` pulse. The first byte read only resets the PROM's counter and is discarded. If the second byte equals 0x08, the scanner emits a single-cycle counter-enable pulse before the search starts. When the run finishes, the scanner raises `done` and holds it, together with the found flag, the address and the checksum verdict, until the next `start`.

Top module: `prom_sig_scan`

## Requirements
- R1: After reset, and in the cycle after any `start`, `done`, `found`, `csum_ok` and `cnt_en` are 0 and `station_addr` is 0. A `start` during a run abandons that run and begins a new one.
- R2: The first byte read is discarded. If the second byte equals 0x08, `cnt_en` is high for exactly one cycle, after the second read and before the first search read. Otherwise `cnt_en` stays low.
- R3: Each search byte is compared with signature byte j, where j is the current match count starting at 0. A hit increments j. On a miss, j becomes 1 if the byte is FF and 0 otherwise. The search ends as soon as j reaches 8.
- R4: The search issues at most 39 reads. If the signature is incomplete after read 39, the run ends with `found`=0, and the total read count is 41.
- R5: Once the signature completes, exactly 8 more reads follow: 6 address bytes, then 2 checksum bytes (low byte first). Address byte k (k=0 first) appears on `station_addr[8k+7:8k]`.
- R6: The checksum runs over three little-endian words (b0|b1<<8, b2|b3<<8, b4|b5<<8) starting from 0. For each word: shift the sum left by 1 and subtract 0xFFFF if the result exceeds 0xFFFF; then add the word and apply the same fold. `csum_ok` is 1 when the result equals the checksum bytes read.
- R7: A final sum of 0xFFFF is compared as 0x0000.
- R8: A checksum mismatch still reports `found`=1 and the address; only `csum_ok` is 0.
- R9: `done` stays high until the next `start`, and no read is requested while `done` is high.
- R10: A byte is taken only in a cycle with `rd_req` and `rd_ack` both high. `rd_req` stays high until that happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new scan (one-cycle pulse) |
| rd_req | output | 1 | Byte read request to the PROM port |
| rd_ack | input | 1 | PROM port delivers `rd_data` this cycle |
| rd_data | input | 8 | Byte from the PROM port |
| cnt_en | output | 1 | One-cycle PROM counter-enable pulse |
| done | output | 1 | Scan finished; held until next start |
| found | output | 1 | Signature located |
| station_addr | output | 48 | Station address, first byte in bits 7:0 |
| csum_ok | output | 1 | Computed checksum matched the stored one |

## Verification
A wrong match count or restart decision shows up at the ports as a different number of reads before `done`, because the read count directly reflects where the tracker believed the signature ended. It also shows up as a shifted address, visible at the end of the same run. A checksum fold error only flips `csum_ok`, so test cases drive address values that force folds at every step, and one that lands exactly on 0xFFFF. Counter-enable mistakes are visible within the first three reads of a run.

// File: rtl/prom_sig_scan.sv
module prom_sig_scan #(
  parameter int          WINDOW     = 32,
  parameter logic [63:0] SIG        = 64'hFF00_55AA_FF00_55AA,
  parameter logic [7:0]  ENABLE_TAG = 8'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        rd_req,
  input  logic        rd_ack,
  input  logic [7:0]  rd_data,
  output logic        cnt_en,
  output logic        done,
  output logic        found,
  output logic [47:0] station_addr,
  output logic        csum_ok
);
  localparam int SIG_LEN = 8;
  localparam int LIMIT   = WINDOW + SIG_LEN - 1;
  localparam int CW      = $clog2(LIMIT + 1);
  localparam int MW      = $clog2(SIG_LEN + 1);
  localparam int NBYTES  = 6;
  localparam int TW      = $clog2(NBYTES + 2);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_PEEK, S_PULSE, S_SRCH, S_TAIL, S_DONE} st_t;
  st_t st;

  logic [CW-1:0] scnt;
  logic [MW-1:0] match, match_nx;
  logic [TW-1:0] tcnt;
  logic [17:0]   sum, s_shift, s_add;
  logic [7:0]    lo_q, sig_b;
  logic [15:0]   fin;

  wire xfer    = rd_req & rd_ack;
  wire [7:0] first_b = SIG[8*SIG_LEN-1 -: 8];

  assign rd_req = (st == S_CLR) | (st == S_PEEK) | (st == S_SRCH) | (st == S_TAIL);
  assign cnt_en = (st == S_PULSE);
  assign done   = (st == S_DONE);

  always_comb begin
    sig_b = '0;
    for (int k = 0; k < SIG_LEN; k++)
      if (match == MW'(k)) sig_b = SIG[8*(SIG_LEN-1-k) +: 8];
  end

  assign match_nx = (rd_data == sig_b) ? match + 1'b1 :
                    (rd_data == first_b) ? MW'(1) : '0;

  function automatic logic [17:0] fold(input logic [17:0] v);
    return (v > 18'h0FFFF) ? v - 18'h0FFFF : v;
  endfunction

  assign s_shift = fold({sum[16:0], 1'b0});
  assign s_add   = fold(s_shift + {2'b00, rd_data, lo_q});
  assign fin     = (sum[15:0] == 16'hFFFF) ? 16'h0000 : sum[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scnt <= '0; match <= '0; tcnt <= '0; sum <= '0; lo_q <= '0;
      found <= 1'b0; csum_ok <= 1'b0; station_addr <= '0;
    end else if (start) begin
      st <= S_CLR;
      scnt <= '0; match <= '0; tcnt <= '0; sum <= '0; lo_q <= '0;
      found <= 1'b0; csum_ok <= 1'b0; station_addr <= '0;
    end else begin
      case (st)
        S_CLR:   if (xfer) st <= S_PEEK;
        S_PEEK:  if (xfer) st <= (rd_data == ENABLE_TAG) ? S_PULSE : S_SRCH;
        S_PULSE: st <= S_SRCH;
        S_SRCH: if (xfer) begin
          match <= match_nx;
          scnt  <= scnt + 1'b1;
          if (match_nx == MW'(SIG_LEN))         st <= S_TAIL;
          else if (scnt == CW'(LIMIT - 1))      st <= S_DONE;
        end
        S_TAIL: if (xfer) begin
          lo_q <= rd_data;
          tcnt <= tcnt + 1'b1;
          for (int k = 0; k < NBYTES; k++)
            if (tcnt == TW'(k)) station_addr[8*k +: 8] <= rd_data;
          if (tcnt[0] && tcnt < TW'(NBYTES)) sum <= s_add;
          if (tcnt == TW'(NBYTES + 1)) begin
            found   <= 1'b1;
            csum_ok <= ({rd_data, lo_q} == fin);
            st      <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && !start |=> rd_req);
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  a_r9_no_read_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> !cnt_en);
  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= CW'(LIMIT));
  a_r3_match_bound: assert property (@(posedge clk) disable iff (!rst_n)
    match <= MW'(SIG_LEN));
  a_r8_ok_implies_found: assert property (@(posedge clk) disable iff (!rst_n)
    csum_ok |-> found);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !found && !csum_ok);
  a_r6_sum_folded: assert property (@(posedge clk) disable iff (!rst_n)
    sum <= 18'h0FFFF);
endmodule

// File: tb/prom_sig_scan_tb.sv
module prom_sig_scan_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_ack = 1'b0;
  logic [7:0] rd_data = '0;
  logic rd_req, cnt_en, done, found, csum_ok;
  logic [47:0] station_addr;

  prom_sig_scan dut_i (.clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
    .rd_ack(rd_ack), .rd_data(rd_data), .cnt_en(cnt_en), .done(done),
    .found(found), .station_addr(station_addr), .csum_ok(csum_ok));

  always #2 clk = ~clk;

  logic [7:0] prom [0:63];
  int ptr = 0, reads = 0, pulses = 0, pulse_at = -1, cyc = 0;
  int checks = 0, fails = 0;
  bit first = 1'b1, rnd_ack = 1'b0, wd_hit = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!start && rd_req && rd_ack) begin
      reads <= reads + 1;
      if (first) first <= 1'b0; else ptr <= ptr + 1;
    end
    if (!start && cnt_en) begin pulses <= pulses + 1; pulse_at <= reads; end
  end

  always @(negedge clk) begin
    rd_ack  = rd_req && (!rnd_ack || ($urandom % 3 != 0));
    rd_data = first ? 8'h3C : prom[ptr];
    if (rst_n && done && !start) chk(!rd_req, "R9 read while done", rd_req, 0);
  end

  function automatic int fold(input int v);
    return (v > 32'hFFFF) ? v - 32'hFFFF : v;
  endfunction

  function automatic int model_csum(input int base);
    int s = 0;
    for (int w = 0; w < 3; w++) begin
      s = fold(s * 2);
      s = fold(s + prom[base + 2*w] + 256 * prom[base + 2*w + 1]);
    end
    if (s == 32'hFFFF) s = 0;
    return s;
  endfunction

  localparam logic [7:0] SG [0:7] = '{8'hFF, 8'h00, 8'h55, 8'hAA, 8'hFF, 8'h00, 8'h55, 8'hAA};

  task automatic fill(input logic [7:0] peek);
    for (int i = 0; i < 64; i++) prom[i] = 8'h11;
    prom[0] = peek;
  endtask

  task automatic put_sig(input int at);
    for (int i = 0; i < 8; i++) prom[at + i] = SG[i];
  endtask

  task automatic put_tail(input int at, input logic [47:0] a, input bit bad);
    int c;
    for (int i = 0; i < 6; i++) prom[at + i] = a[8*i +: 8];
    c = model_csum(at);
    if (bad) c = c ^ 1;
    prom[at + 6] = c[7:0];
    prom[at + 7] = c[15:8];
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk); #0;
    first = 1'b1; ptr = 0; reads = 0; pulses = 0; pulse_at = -1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !found && !csum_ok && station_addr == 0, "R1 cleared by start", done, 0);
  endtask

  task automatic wait_done();
    while (!done && !wd_hit) @(negedge clk);
  endtask

  task automatic run(input string tag);
    int j = 0, i = 0, exp_reads, exp_csum, base;
    bit exp_found, exp_ok;
    logic [47:0] exp_addr = '0;
    while (j < 8 && i < 39) begin
      if (prom[1 + i] == SG[j]) j++;
      else j = (prom[1 + i] == 8'hFF) ? 1 : 0;
      i++;
    end
    exp_found = (j == 8);
    base = 1 + i;
    exp_reads = exp_found ? 2 + i + 8 : 2 + i;
    if (exp_found) begin
      for (int k = 0; k < 6; k++) exp_addr[8*k +: 8] = prom[base + k];
      exp_csum = model_csum(base);
      exp_ok = (exp_csum == {prom[base + 7], prom[base + 6]});
    end else exp_ok = 1'b0;
    pulse_start();
    wait_done();
    chk(found == exp_found, {tag, " R3/R4 found"}, found, exp_found);
    chk(reads == exp_reads, {tag, " R4/R5 read count"}, reads, exp_reads);
    chk(station_addr == exp_addr, {tag, " R5 address"}, station_addr, exp_addr);
    chk(csum_ok == exp_ok, {tag, " R6 checksum"}, csum_ok, exp_ok);
    if (prom[0] == 8'h08) begin
      chk(pulses == 1, {tag, " R2 pulse count"}, pulses, 1);
      chk(pulse_at == 2, {tag, " R2 pulse position"}, pulse_at, 2);
    end else chk(pulses == 0, {tag, " R2 no pulse"}, pulses, 0);
    repeat (5) @(negedge clk);
    chk(done && reads == exp_reads, {tag, " R9 done held"}, reads, exp_reads);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prom[i] = 8'h11;
    repeat (3) @(negedge clk);
    chk(!done && !found && !rd_req && !cnt_en && station_addr == 0, "R1 reset state", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req && !done, "R1 idle after reset", rd_req, 0);

    fill(8'h08); put_sig(1); put_tail(9, 48'h5634_122B_0008, 0);
    run("A"); chk(found && csum_ok, "A R6 good sum", csum_ok, 1);

    rnd_ack = 1'b1;
    fill(8'h00); prom[1] = 8'hFF; prom[2] = 8'h00; prom[3] = 8'h55;
    put_sig(4); put_tail(12, 48'hA1B2_C3D4_E5F6, 1);
    run("B"); chk(found && !csum_ok, "B R8 bad sum keeps found", found, 1);

    fill(8'h00); run("C");
    chk(!found && reads == 41, "C R4 window exhaust", reads, 41);

    fill(8'h08); put_sig(32); put_tail(40, 48'h0102_0304_0506, 0);
    run("D"); chk(found, "D R4 match on last read", found, 1);

    fill(8'h00); put_sig(33); run("E");
    chk(!found, "E R4 one past window", found, 0);

    fill(8'h00); put_sig(1); put_tail(9, 48'hFFFF_0000_0000, 0);
    run("F");
    chk(prom[15] == 0 && prom[16] == 0 && csum_ok, "F R7 0xFFFF as zero", csum_ok, 1);

    fill(8'h00); put_sig(5); put_tail(13, 48'hFFFF_FFFF_FFFF, 0);
    run("G"); chk(csum_ok, "G R6 heavy fold", csum_ok, 1);

    rnd_ack = 1'b0;
    fill(8'h08); put_sig(1); put_tail(9, 48'h0000_0000_0000, 0);
    pulse_start();
    repeat (6) @(negedge clk);
    chk(!done, "H R1 mid-run", done, 0);
    run("H");

    if (!wd_hit) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait (cyc > 100000);
    wd_hit = 1'b1;
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule